// File: doc/BRIEF.md
# Keyed Index/Data Configuration Register Bank

This block is a byte-wide bank of 256 chipset configuration registers. Software reaches the bank through two I/O addresses. A write to the index port selects a register. The data port then reads or writes the selected register. Each register has its own reset value and its own mask of writable bits. Bits outside the mask are stored as zero.

A lock protects the bank. Writes to any register except the key register take effect only while the key register holds the unlock value 0xC5. The key register itself can always be written, so software locks the bank by writing any other value to it. A CPU-type strap hides part of the index space from reads. Selected register fields leave the block as plain control outputs: shadow region and control, SMM control, the two cache enables and the port-92 enable.

The I/O side is a plain single-cycle strobe with no back-pressure. A write strobe is accepted in the cycle it is high. Read data is combinational and is valid while the address is presented.

Top module: `cfgb_top`

## Requirements
- R1: A write strobe at I/O address 0x22 loads the data byte into the index register. Data-port accesses at I/O address 0x23 then target the register that the index names.
- R2: After reset, registers hold these values: 0x01=0x0F, 0x02=0x0F, 0x10=0xF1, 0x11=0xFF, 0x15=0x20, 0x16=0x30, 0x19=0x04, 0x21=0x72, 0x28=0x02, 0x2B=0xDB, 0x3C=0x03, 0x3D=0x01, 0x40=0x03. Every other register holds 0x00.
- R3: A data-port write with index 0x03 always stores the full byte, whatever the lock state.
- R4: A data-port write to any index other than 0x03 changes nothing unless register 0x03 held 0xC5 before the write.
- R5: An unlocked write stores the data ANDed with that register's mask. The masks are 0x14:0xBF, 0x15:0xF1, 0x1E:0x40, 0x22:0xFD, 0x2B:0xBF, 0x36:0xE5, 0x37:0xEF, 0x3D:0x07 and 0x40:0x3F. All other registers use 0xFF.
- R6: While the strap input is high, a data-port read returns 0xFF when the index is 0x20 or 0xC0 and above. Otherwise it returns the stored value.
- R7: A read at any address other than 0x23 returns 0xFF. A write strobe at any address other than 0x22 or 0x23 changes no state.
- R8: The internal-cache enable output follows bit 0 of register 0x16, and the external-cache enable follows bit 1. The port-92 enable follows bit 4 of register 0x29. The shadow region output is register 0x13, the shadow control output is register 0x14, and the SMM control output is register 0x19.
- R9: A write takes effect at the clock edge where the strobe is high. Reads before that edge return the old value, and reads after it return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Single-cycle write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data |
| cpu_strap | input | 1 | CPU-type strap that hides reads |
| shadow_region | output | 8 | Shadow region field (register 0x13) |
| shadow_ctl | output | 8 | Shadow control field (register 0x14) |
| smm_ctl | output | 8 | SMM control field (register 0x19) |
| icache_en | output | 1 | Internal-cache enable |
| ecache_en | output | 1 | External-cache enable |
| port92_en | output | 1 | Port-92 enable |

## Verification
The write path has one register on it. A write becomes visible on read data and on the field outputs immediately after the clock edge on which the strobe is high. A read has zero cycles of latency.

The bench drives the strobe from the falling edge. It samples read data and the field outputs shortly after a falling edge, so each result is read one half-cycle after the write edge. For R9 it also reads the old value before the edge.

Full sweeps over all 256 indices cover these cases:
- the reset state;
- locked writes;
- unlocked masked writes;
- strap-hidden reads.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int IDX_W = 8;
  localparam int NREG  = 1 << IDX_W;
  localparam int DW    = 8;

  function automatic logic [DW-1:0] rst_val(input int i);
    case (i)
      8'h01, 8'h02: rst_val = 8'h0F;
      8'h10: rst_val = 8'hF1;
      8'h11: rst_val = 8'hFF;
      8'h15: rst_val = 8'h20;
      8'h16: rst_val = 8'h30;
      8'h19: rst_val = 8'h04;
      8'h21: rst_val = 8'h72;
      8'h28: rst_val = 8'h02;
      8'h2B: rst_val = 8'hDB;
      8'h3C: rst_val = 8'h03;
      8'h3D: rst_val = 8'h01;
      8'h40: rst_val = 8'h03;
      default: rst_val = 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] wr_mask(input int i);
    case (i)
      8'h14, 8'h2B: wr_mask = 8'hBF;
      8'h15: wr_mask = 8'hF1;
      8'h1E: wr_mask = 8'h40;
      8'h22: wr_mask = 8'hFD;
      8'h36: wr_mask = 8'hE5;
      8'h37: wr_mask = 8'hEF;
      8'h3D: wr_mask = 8'h07;
      8'h40: wr_mask = 8'h3F;
      default: wr_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic is_hidden(input logic [IDX_W-1:0] i);
    is_hidden = (i == 8'h20) || (i >= 8'hC0);
  endfunction
endpackage

// File: rtl/cfgb_port_dec.sv
module cfgb_port_dec #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            io_addr,
  input  logic                         io_wr,
  input  logic [cfgb_pkg::DW-1:0]      io_wdata,
  output logic [cfgb_pkg::IDX_W-1:0]   idx_q,
  output logic                         data_wr,
  output logic                         data_sel
);
  logic index_wr;

  always_comb begin
    index_wr = io_wr && (io_addr == INDEX_PORT);
    data_sel = (io_addr == DATA_PORT);
    data_wr  = io_wr && data_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (index_wr) idx_q <= io_wdata[cfgb_pkg::IDX_W-1:0];
  end
endmodule

// File: rtl/cfgb_reg_file.sv
module cfgb_reg_file #(
  parameter int KEY_IDX = 8'h03,
  parameter logic [cfgb_pkg::DW-1:0] KEY_VAL = 8'hC5
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        data_wr,
  input  logic [cfgb_pkg::IDX_W-1:0]                  idx,
  input  logic [cfgb_pkg::DW-1:0]                     wdata,
  output logic [cfgb_pkg::NREG-1:0][cfgb_pkg::DW-1:0] regs
);
  logic unlocked;
  assign unlocked = (regs[KEY_IDX] == KEY_VAL);

  for (genvar g = 0; g < cfgb_pkg::NREG; g++) begin : g_reg
    localparam logic [cfgb_pkg::DW-1:0] DEF  = cfgb_pkg::rst_val(g);
    localparam logic [cfgb_pkg::DW-1:0] MASK = cfgb_pkg::wr_mask(g);
    logic hit;
    assign hit = data_wr && (idx == cfgb_pkg::IDX_W'(g));
    if (g == KEY_IDX) begin : g_key
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs[g] <= DEF;
        else if (hit) regs[g] <= wdata;
      end
    end else begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               regs[g] <= DEF;
        else if (hit && unlocked) regs[g] <= wdata & MASK;
      end
    end
  end
endmodule

// File: rtl/cfgb_read_mux.sv
module cfgb_read_mux (
  input  logic [cfgb_pkg::NREG-1:0][cfgb_pkg::DW-1:0] regs,
  input  logic [cfgb_pkg::IDX_W-1:0]                  idx,
  input  logic                                        data_sel,
  input  logic                                        strap,
  output logic [cfgb_pkg::DW-1:0]                     rdata
);
  always_comb begin
    if (!data_sel)                              rdata = '1;
    else if (strap && cfgb_pkg::is_hidden(idx)) rdata = '1;
    else                                        rdata = regs[idx];
  end
endmodule

// File: rtl/cfgb_top.sv
module cfgb_top #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              cpu_strap,
  output logic [7:0]        shadow_region,
  output logic [7:0]        shadow_ctl,
  output logic [7:0]        smm_ctl,
  output logic              icache_en,
  output logic              ecache_en,
  output logic              port92_en
);
  logic [cfgb_pkg::IDX_W-1:0]                  idx_q;
  logic                                        data_wr;
  logic                                        data_sel;
  logic [cfgb_pkg::NREG-1:0][cfgb_pkg::DW-1:0] regs;

  cfgb_port_dec #(.ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .idx_q(idx_q), .data_wr(data_wr), .data_sel(data_sel));

  cfgb_reg_file u_rf (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx(idx_q), .wdata(io_wdata), .regs(regs));

  cfgb_read_mux u_rd (
    .regs(regs), .idx(idx_q), .data_sel(data_sel), .strap(cpu_strap), .rdata(io_rdata));

  assign shadow_region = regs[8'h13];
  assign shadow_ctl    = regs[8'h14];
  assign smm_ctl       = regs[8'h19];
  assign icache_en     = regs[8'h16][0];
  assign ecache_en     = regs[8'h16][1];
  assign port92_en     = regs[8'h29][4];
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker (
  input logic                                        clk,
  input logic                                        rst_n,
  input logic [15:0]                                 io_addr,
  input logic                                        io_wr,
  input logic [7:0]                                  io_wdata,
  input logic [7:0]                                  io_rdata,
  input logic                                        cpu_strap,
  input logic                                        icache_en,
  input logic                                        port92_en,
  input logic [cfgb_pkg::IDX_W-1:0]                  idx_q,
  input logic [cfgb_pkg::NREG-1:0][cfgb_pkg::DW-1:0] regs
);
  logic dwr;
  logic [7:0] past_idx_mask;
  assign dwr = io_wr && (io_addr == 16'h0023);
  assign past_idx_mask = cfgb_pkg::wr_mask(int'(idx_q));

  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h0022) |=> idx_q == $past(io_wdata));

  p_key_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == 8'h03) |=> regs[8'h03] == $past(io_wdata));

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q != 8'h03 && regs[8'h03] != 8'hC5) |=> regs[$past(idx_q)] == $past(regs[idx_q]));

  p_masked_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q != 8'h03 && regs[8'h03] == 8'hC5) |=> regs[$past(idx_q)] == ($past(io_wdata) & $past(past_idx_mask)));

  p_hidden_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strap && io_addr == 16'h0023 && (idx_q == 8'h20 || idx_q >= 8'hC0)) |-> io_rdata == 8'hFF);

  p_other_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != 16'h0023) |-> io_rdata == 8'hFF);

  p_field_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (icache_en == regs[8'h16][0]) && (port92_en == regs[8'h29][4]));
endmodule

bind cfgb_top cfgb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .cpu_strap(cpu_strap), .icache_en(icache_en), .port92_en(port92_en),
  .idx_q(idx_q), .regs(regs));

// File: tb/test_cfgb_top.sv
`timescale 1ns/1ps
module test_cfgb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = 16'h0000;
  logic io_wr = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic cpu_strap = 0;
  logic [7:0] shadow_region, shadow_ctl, smm_ctl;
  logic icache_en, ecache_en, port92_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfgb_top i_cfgb_top (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .cpu_strap(cpu_strap), .shadow_region(shadow_region),
    .shadow_ctl(shadow_ctl), .smm_ctl(smm_ctl), .icache_en(icache_en),
    .ecache_en(ecache_en), .port92_en(port92_en));

  function automatic logic [7:0] exp_def(input int i);
    logic [7:0] v;
    v = 8'h00;
    if (i == 1 || i == 2) v = 8'h0F;
    if (i == 16) v = 8'hF1;
    if (i == 17) v = 8'hFF;
    if (i == 21) v = 8'h20;
    if (i == 22) v = 8'h30;
    if (i == 25) v = 8'h04;
    if (i == 33) v = 8'h72;
    if (i == 40) v = 8'h02;
    if (i == 43) v = 8'hDB;
    if (i == 60) v = 8'h03;
    if (i == 61) v = 8'h01;
    if (i == 64) v = 8'h03;
    return v;
  endfunction

  function automatic logic [7:0] exp_mask(input int i);
    logic [7:0] m;
    m = 8'hFF;
    if (i == 20 || i == 43) m = 8'hBF;
    if (i == 21) m = 8'hF1;
    if (i == 30) m = 8'h40;
    if (i == 34) m = 8'hFD;
    if (i == 54) m = 8'hE5;
    if (i == 55) m = 8'hEF;
    if (i == 61) m = 8'h07;
    if (i == 64) m = 8'h3F;
    return m;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] d);
    wr(16'h0022, idx);
    io_addr = 16'h0023;
    #1 d = io_rdata;
  endtask

  initial begin
    #(10 * 200000);
    $display("FAIL watchdog act=00 exp=01");
    fails++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails + 0);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state, R1 index selection
    for (int i = 0; i < 256; i++) begin
      rd(8'(i), d);
      chk("R2", d, exp_def(i));
    end
    chk("R8", {7'd0, icache_en}, 8'h00);
    chk("R8", {7'd0, ecache_en}, 8'h00);
    chk("R8", smm_ctl, 8'h04);
    // R4 locked writes ignored
    for (int i = 0; i < 256; i++) begin
      if (i != 3) begin
        wr(16'h0022, 8'(i));
        wr(16'h0023, 8'hFF);
      end
    end
    for (int i = 0; i < 256; i++) begin
      rd(8'(i), d);
      chk("R4", d, exp_def(i));
    end
    // R3 key always writable
    wr(16'h0022, 8'h03); wr(16'h0023, 8'h77);
    rd(8'h03, d); chk("R3", d, 8'h77);
    wr(16'h0022, 8'h03); wr(16'h0023, 8'hC5);
    rd(8'h03, d); chk("R3", d, 8'hC5);
    // R5 masked unlocked writes
    for (int i = 0; i < 256; i++) begin
      if (i != 3) begin
        wr(16'h0022, 8'(i));
        wr(16'h0023, 8'(i) ^ 8'h5A);
      end
    end
    for (int i = 0; i < 256; i++) begin
      rd(8'(i), d);
      chk("R5", d, (i == 3) ? 8'hC5 : ((8'(i) ^ 8'h5A) & exp_mask(i)));
    end
    // R6 strap hiding
    cpu_strap = 1;
    for (int i = 0; i < 256; i++) begin
      rd(8'(i), d);
      chk("R6", d, (i == 32 || i >= 192) ? 8'hFF :
                   ((i == 3) ? 8'hC5 : ((8'(i) ^ 8'h5A) & exp_mask(i))));
    end
    cpu_strap = 0;
    // R7 other addresses
    wr(16'h0022, 8'h16);
    io_addr = 16'h0022; #1 chk("R7", io_rdata, 8'hFF);
    io_addr = 16'h0080; #1 chk("R7", io_rdata, 8'hFF);
    wr(16'h0024, 8'hAA);
    wr(16'h0123, 8'hAA);
    io_addr = 16'h0023; #1 chk("R7", io_rdata, 8'h16 ^ 8'h5A);
    // R8 field outputs and R9 timing
    @(negedge clk);
    io_addr = 16'h0023; io_wdata = 8'h03; io_wr = 1;
    #1 chk("R9", io_rdata, 8'h16 ^ 8'h5A);
    @(negedge clk); io_wr = 0;
    #1 chk("R9", io_rdata, 8'h03);
    chk("R8", {7'd0, icache_en}, 8'h01);
    chk("R8", {7'd0, ecache_en}, 8'h01);
    wr(16'h0022, 8'h16); wr(16'h0023, 8'h02);
    #1 chk("R8", {6'd0, ecache_en, icache_en}, 8'h02);
    wr(16'h0022, 8'h29); wr(16'h0023, 8'h10);
    #1 chk("R8", {7'd0, port92_en}, 8'h01);
    wr(16'h0023, 8'hEF);
    #1 chk("R8", {7'd0, port92_en}, 8'h00);
    wr(16'h0022, 8'h13); wr(16'h0023, 8'hA5);
    wr(16'h0022, 8'h14); wr(16'h0023, 8'hFF);
    wr(16'h0022, 8'h19); wr(16'h0023, 8'h38);
    #1 chk("R8", shadow_region, 8'hA5);
    chk("R8", shadow_ctl, 8'hBF);
    chk("R8", smm_ctl, 8'h38);
    // R4 relock
    wr(16'h0022, 8'h03); wr(16'h0023, 8'h00);
    wr(16'h0022, 8'h13); wr(16'h0023, 8'h11);
    rd(8'h13, d); chk("R4", d, 8'hA5);
    chk("R4", shadow_region, 8'hA5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule